// File: doc/BRIEF.md
# Configuration Security Mode Controller

This controller stands between an incoming configuration stream and the configuration fabric. It reads the leading header word of each stream to learn whether the payload is encrypted. Plain payload goes straight to the fabric. Encrypted payload goes to an external decryption datapath, together with a selected key and a flag that names the store it came from. The datapath returns one key-check verdict after the first block. The controller then either completes the session or enters a failure state that only a reset can leave.

Two key stores are held inside the block. One is one-time programmable and models fuses. The other is rewritable and models battery-backed registers. Each store has a presence flag that is set when a full key has been shifted in through a one-bit serial programming port. A one-time tamper-protection bit, which can only be set once the fuse store holds a key, refuses plain streams and locks out all key programming. No port reads back key bits or configuration data. The key leaves the block only on the decryption key output, and only while an encrypted session is open.

The session controller is cleared by `rst_n`. The stores and the tamper bit are cleared only by `keys_clr_n`, which stands for a blank fuse array and a lost battery.

Top module: `cfgsec_ctrl`

## Requirements
- R1: A key is loaded as KEY_W serial bits on `kp_bit` while `kp_valid` is high, the first bit becoming the key MSB; `kp_to_nv`=1 targets the fuse store, 0 the volatile store; the store's presence flag is set in the cycle after its last bit.
- R2: Once `nv_present` is set, the fuse store ignores every further write and its key never changes.
- R3: The volatile store may be reloaded; its presence flag drops after the first bit of a new load and returns when the new key is complete, and the new key is then the one used.
- R4: `tp_req` sets `tamper_on` only if `nv_present` is already set; once set, `tamper_on` stays set until `keys_clr_n`.
- R5: While `tamper_on` is set, key programming to either store is ignored.
- R6: A header is a `cfg_valid` word with `cfg_sop` high; bit 0 of the header is the encrypted flag. A plain header with tamper protection off routes each following word to `fab_data` one cycle later, and `cfg_done` rises after the word marked `cfg_eop`.
- R7: A plain header while `tamper_on` is set makes `cfg_fail` rise in the next cycle, and nothing is forwarded.
- R8: An encrypted header selects the fuse key when `nv_present` is set, else the volatile key; `dec_key_sel` is 1 for the fuse key. With no key present the session fails at the header.
- R9: In an encrypted session, words go to `dec_data` one cycle later; a failing key check moves to failure with no further forwarding, and a passing check leads to `cfg_done` once the `cfg_eop` word has been seen, whether it came before or after the verdict.
- R10: `cfg_done` and `cfg_fail` are never high together, both persist until `rst_n`, and `rst_n` leaves key stores and the tamper bit intact.
- R11: A readback request on `rb_req` is always answered by `rb_refuse` in the next cycle, and `dec_key` is zero outside an open encrypted session.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the session logic |
| keys_clr_n | input | 1 | Active-low clear of key stores and tamper bit |
| kp_valid | input | 1 | Serial key bit valid |
| kp_to_nv | input | 1 | Target store: 1 fuse, 0 volatile |
| kp_bit | input | 1 | Serial key bit, MSB first |
| tp_req | input | 1 | Request to set tamper protection |
| cfg_valid | input | 1 | Stream word valid |
| cfg_sop | input | 1 | Word is a header |
| cfg_eop | input | 1 | Word is the last payload word |
| cfg_data | input | DATA_W | Stream word |
| fab_valid | output | 1 | Plain word to fabric valid |
| fab_data | output | DATA_W | Plain word to fabric |
| dec_valid | output | 1 | Word to decryption datapath valid |
| dec_data | output | DATA_W | Word to decryption datapath |
| dec_key_sel | output | 1 | Selected key is the fuse key |
| dec_key | output | KEY_W | Selected key, zero when no session is open |
| kchk_valid | input | 1 | Key-check verdict valid |
| kchk_pass | input | 1 | Key-check verdict passed |
| rb_req | input | 1 | Readback request |
| rb_refuse | output | 1 | Readback refused |
| nv_present | output | 1 | Fuse store holds a key |
| vol_present | output | 1 | Volatile store holds a key |
| tamper_on | output | 1 | Tamper protection set |
| cfg_done | output | 1 | Configuration completed |
| cfg_fail | output | 1 | Configuration failed |

## Verification
The bench goes after the key-check verdict that arrives after the final word, where a design that ignored an earlier end of stream would hang and never complete. It tries to rewrite the fuse key and to program either store under tamper protection, where a leaky lock would show up as a changed key or a dropped presence flag. It sends a plain stream under protection, which a careless design would forward instead of failing. It also checks that a session reset keeps the stores and that the fuse key wins over the volatile key when both are present.

// File: rtl/cfgsec_pkg.sv
package cfgsec_pkg;

  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_PLAIN   = 3'd1,
    S_ENC_CHK = 3'd2,
    S_ENC_RUN = 3'd3,
    S_DONE    = 3'd4,
    S_FAIL    = 3'd5
  } seq_state_t;

  typedef enum logic [1:0] {
    ROUTE_FAIL    = 2'd0,
    ROUTE_PLAIN   = 2'd1,
    ROUTE_DECRYPT = 2'd2
  } hdr_route_t;

  typedef struct packed {
    logic usable;
    logic use_nv;
  } key_pick_t;

  // Fuse key has priority over the volatile key.
  function automatic key_pick_t pick_key(input logic nv_ok, input logic vol_ok);
    key_pick_t p;
    p.usable = nv_ok | vol_ok;
    p.use_nv = nv_ok;
    return p;
  endfunction

  // Decide where a stream goes from its header flag and the security state.
  function automatic hdr_route_t route_header(input logic enc, input logic tamper,
                                              input logic nv_ok, input logic vol_ok);
    key_pick_t p;
    p = pick_key(nv_ok, vol_ok);
    if (!enc) return tamper ? ROUTE_FAIL : ROUTE_PLAIN;
    return p.usable ? ROUTE_DECRYPT : ROUTE_FAIL;
  endfunction

endpackage

// File: rtl/cfgsec_keystore.sv
module cfgsec_keystore #(
  parameter int KEY_W    = 256,
  parameter bit ONE_TIME = 1'b0
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             bit_vld,
  input  logic             bit_val,
  input  logic             lock,
  output logic [KEY_W-1:0] key_o,
  output logic             present_o,
  output logic             commit_o
);
  localparam int CNT_W = (KEY_W > 1) ? $clog2(KEY_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(KEY_W - 1);

  logic [KEY_W-1:0] key_q;
  logic [CNT_W-1:0] cnt_q;
  logic             present_q;
  logic             accept;
  logic             last_bit;

  generate
    if (ONE_TIME) begin : g_otp
      assign accept = bit_vld & ~lock & ~present_q;
    end else begin : g_rw
      assign accept = bit_vld & ~lock;
    end
  endgenerate

  assign last_bit = (cnt_q == LAST_IDX);

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      key_q     <= '0;
      cnt_q     <= '0;
      present_q <= 1'b0;
    end else if (accept) begin
      key_q <= {key_q[KEY_W-2:0], bit_val};
      if (cnt_q == '0) present_q <= 1'b0;
      if (last_bit) begin
        cnt_q     <= '0;
        present_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign key_o     = key_q;
  assign present_o = present_q;
  assign commit_o  = accept & last_bit;
endmodule

// File: rtl/cfgsec_tamper_fuse.sv
module cfgsec_tamper_fuse (
  input  logic clk,
  input  logic clr_n,
  input  logic req,
  input  logic nv_ok,
  output logic tamper_o,
  output logic set_evt_o
);
  logic tamper_q;

  assign set_evt_o = req & nv_ok & ~tamper_q;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) tamper_q <= 1'b0;
    else if (set_evt_o) tamper_q <= 1'b1;
  end

  assign tamper_o = tamper_q;
endmodule

// File: rtl/cfgsec_seq.sv
module cfgsec_seq
  import cfgsec_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ENC_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic              cfg_sop,
  input  logic              cfg_eop,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic              tamper,
  input  logic              nv_ok,
  input  logic              vol_ok,
  input  logic              kchk_valid,
  input  logic              kchk_pass,
  output logic              fab_valid,
  output logic [DATA_W-1:0] fab_data,
  output logic              dec_valid,
  output logic [DATA_W-1:0] dec_data,
  output logic              use_nv_o,
  output logic              dec_active_o,
  output logic              done_o,
  output logic              fail_o,
  output logic              hdr_evt_o,
  output logic              hdr_enc_o
);
  seq_state_t state_q, state_d;
  logic       use_nv_q, use_nv_d;
  logic       eop_seen_q, eop_seen_d;
  logic       fwd_plain, fwd_dec;
  logic       key_bad;
  hdr_route_t route;
  key_pick_t  pick;

  logic              fab_valid_q, dec_valid_q;
  logic [DATA_W-1:0] fab_data_q, dec_data_q;

  assign hdr_enc_o = cfg_data[ENC_BIT];
  assign route     = route_header(hdr_enc_o, tamper, nv_ok, vol_ok);
  assign pick      = pick_key(nv_ok, vol_ok);
  assign key_bad   = kchk_valid & ~kchk_pass;

  always_comb begin
    state_d    = state_q;
    use_nv_d   = use_nv_q;
    eop_seen_d = eop_seen_q;
    fwd_plain  = 1'b0;
    fwd_dec    = 1'b0;
    hdr_evt_o  = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (cfg_valid && cfg_sop) begin
          hdr_evt_o = 1'b1;
          unique case (route)
            ROUTE_PLAIN:   state_d = S_PLAIN;
            ROUTE_DECRYPT: begin
              state_d    = S_ENC_CHK;
              use_nv_d   = pick.use_nv;
              eop_seen_d = 1'b0;
            end
            default:       state_d = S_FAIL;
          endcase
        end
      end
      S_PLAIN: begin
        if (cfg_valid) begin
          fwd_plain = 1'b1;
          if (cfg_eop) state_d = S_DONE;
        end
      end
      S_ENC_CHK: begin
        if (cfg_valid && !key_bad) begin
          fwd_dec = 1'b1;
          if (cfg_eop) eop_seen_d = 1'b1;
        end
        if (kchk_valid) begin
          if (!kchk_pass) state_d = S_FAIL;
          else if (eop_seen_q || (cfg_valid && cfg_eop)) state_d = S_DONE;
          else state_d = S_ENC_RUN;
        end
      end
      S_ENC_RUN: begin
        if (cfg_valid) begin
          fwd_dec = 1'b1;
          if (cfg_eop) state_d = S_DONE;
        end
      end
      S_DONE:  state_d = S_DONE;
      S_FAIL:  state_d = S_FAIL;
      default: state_d = S_FAIL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      use_nv_q    <= 1'b0;
      eop_seen_q  <= 1'b0;
      fab_valid_q <= 1'b0;
      dec_valid_q <= 1'b0;
      fab_data_q  <= '0;
      dec_data_q  <= '0;
    end else begin
      state_q     <= state_d;
      use_nv_q    <= use_nv_d;
      eop_seen_q  <= eop_seen_d;
      fab_valid_q <= fwd_plain;
      dec_valid_q <= fwd_dec;
      if (fwd_plain) fab_data_q <= cfg_data;
      if (fwd_dec)   dec_data_q <= cfg_data;
    end
  end

  assign fab_valid    = fab_valid_q;
  assign fab_data     = fab_data_q;
  assign dec_valid    = dec_valid_q;
  assign dec_data     = dec_data_q;
  assign use_nv_o     = use_nv_q;
  assign dec_active_o = (state_q == S_ENC_CHK) || (state_q == S_ENC_RUN);
  assign done_o       = (state_q == S_DONE);
  assign fail_o       = (state_q == S_FAIL);
endmodule

// File: rtl/cfgsec_ctrl.sv
module cfgsec_ctrl #(
  parameter int KEY_W   = 256,
  parameter int DATA_W  = 32,
  parameter int ENC_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              keys_clr_n,
  input  logic              kp_valid,
  input  logic              kp_to_nv,
  input  logic              kp_bit,
  input  logic              tp_req,
  input  logic              cfg_valid,
  input  logic              cfg_sop,
  input  logic              cfg_eop,
  input  logic [DATA_W-1:0] cfg_data,
  output logic              fab_valid,
  output logic [DATA_W-1:0] fab_data,
  output logic              dec_valid,
  output logic [DATA_W-1:0] dec_data,
  output logic              dec_key_sel,
  output logic [KEY_W-1:0]  dec_key,
  input  logic              kchk_valid,
  input  logic              kchk_pass,
  input  logic              rb_req,
  output logic              rb_refuse,
  output logic              nv_present,
  output logic              vol_present,
  output logic              tamper_on,
  output logic              cfg_done,
  output logic              cfg_fail
);
  logic [KEY_W-1:0] nv_key_q, vol_key_q;
  logic             nv_commit, vol_commit, tamper_set_evt;
  logic             hdr_evt, hdr_enc;
  logic             use_nv, dec_active;
  logic             rb_refuse_q;

  cfgsec_keystore #(.KEY_W(KEY_W), .ONE_TIME(1'b1)) u_nv_store (
    .clk(clk), .clr_n(keys_clr_n),
    .bit_vld(kp_valid & kp_to_nv), .bit_val(kp_bit), .lock(tamper_on),
    .key_o(nv_key_q), .present_o(nv_present), .commit_o(nv_commit)
  );

  cfgsec_keystore #(.KEY_W(KEY_W), .ONE_TIME(1'b0)) u_vol_store (
    .clk(clk), .clr_n(keys_clr_n),
    .bit_vld(kp_valid & ~kp_to_nv), .bit_val(kp_bit), .lock(tamper_on),
    .key_o(vol_key_q), .present_o(vol_present), .commit_o(vol_commit)
  );

  cfgsec_tamper_fuse u_tamper (
    .clk(clk), .clr_n(keys_clr_n), .req(tp_req), .nv_ok(nv_present),
    .tamper_o(tamper_on), .set_evt_o(tamper_set_evt)
  );

  cfgsec_seq #(.DATA_W(DATA_W), .ENC_BIT(ENC_BIT)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cfg_valid(cfg_valid), .cfg_sop(cfg_sop), .cfg_eop(cfg_eop), .cfg_data(cfg_data),
    .tamper(tamper_on), .nv_ok(nv_present), .vol_ok(vol_present),
    .kchk_valid(kchk_valid), .kchk_pass(kchk_pass),
    .fab_valid(fab_valid), .fab_data(fab_data),
    .dec_valid(dec_valid), .dec_data(dec_data),
    .use_nv_o(use_nv), .dec_active_o(dec_active),
    .done_o(cfg_done), .fail_o(cfg_fail),
    .hdr_evt_o(hdr_evt), .hdr_enc_o(hdr_enc)
  );

  // Readback is never granted; every request is answered with a refusal.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rb_refuse_q <= 1'b0;
    else        rb_refuse_q <= rb_req;
  end
  assign rb_refuse = rb_refuse_q;

  assign dec_key_sel = dec_active & use_nv;
  assign dec_key     = !dec_active ? '0 : (use_nv ? nv_key_q : vol_key_q);
endmodule

// File: rtl/cfgsec_ctrl_chk.sv
module cfgsec_ctrl_chk #(
  parameter int KEY_W = 256
) (
  input logic             clk,
  input logic             rst_n,
  input logic             keys_clr_n,
  input logic             cfg_done,
  input logic             cfg_fail,
  input logic             rb_req,
  input logic             rb_refuse,
  input logic             tamper_on,
  input logic             nv_present,
  input logic             hdr_evt,
  input logic             hdr_enc,
  input logic             fab_valid,
  input logic             dec_valid,
  input logic [KEY_W-1:0] nv_key_q,
  input logic [KEY_W-1:0] vol_key_q
);
  assert_fail_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n || !keys_clr_n)
    cfg_fail |=> cfg_fail);
  assert_done_fail_excl_R10: assert property (@(posedge clk) disable iff (!rst_n || !keys_clr_n)
    !(cfg_done && cfg_fail));
  assert_rb_refused_R11: assert property (@(posedge clk) disable iff (!rst_n || !keys_clr_n)
    rb_req |=> rb_refuse);
  assert_tamper_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n || !keys_clr_n)
    tamper_on |=> tamper_on);
  assert_tamper_needs_nv_R4: assert property (@(posedge clk) disable iff (!rst_n || !keys_clr_n)
    $rose(tamper_on) |-> nv_present);
  assert_nv_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n || !keys_clr_n)
    nv_present |=> nv_present && $stable(nv_key_q));
  assert_prog_lock_R5: assert property (@(posedge clk) disable iff (!rst_n || !keys_clr_n)
    tamper_on |=> $stable(nv_key_q) && $stable(vol_key_q));
  assert_plain_rejected_R7: assert property (@(posedge clk) disable iff (!rst_n || !keys_clr_n)
    hdr_evt && !hdr_enc && tamper_on |=> cfg_fail);
  assert_fail_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n || !keys_clr_n)
    cfg_fail |-> !fab_valid && !dec_valid);
endmodule

bind cfgsec_ctrl cfgsec_ctrl_chk #(.KEY_W(KEY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .keys_clr_n(keys_clr_n),
  .cfg_done(cfg_done), .cfg_fail(cfg_fail),
  .rb_req(rb_req), .rb_refuse(rb_refuse),
  .tamper_on(tamper_on), .nv_present(nv_present),
  .hdr_evt(hdr_evt), .hdr_enc(hdr_enc),
  .fab_valid(fab_valid), .dec_valid(dec_valid),
  .nv_key_q(nv_key_q), .vol_key_q(vol_key_q)
);

// File: tb/cfgsec_ctrl_tb.sv
module cfgsec_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int KEY_W  = 256;
  localparam int DATA_W = 32;
  localparam int WATCHDOG = 100000;

  typedef struct packed {
    logic       enc;
    logic       pass;
    logic [3:0] nw;
    logic [3:0] cnt;
    logic       done;
    logic       fail;
  } vec_t;

  // Sessions with only the volatile key present and protection off.
  localparam vec_t VEC [6] = '{
    '{enc:1'b0, pass:1'b0, nw:4'd3, cnt:4'd3, done:1'b1, fail:1'b0},
    '{enc:1'b1, pass:1'b1, nw:4'd4, cnt:4'd4, done:1'b1, fail:1'b0},
    '{enc:1'b1, pass:1'b0, nw:4'd4, cnt:4'd1, done:1'b0, fail:1'b1},
    '{enc:1'b0, pass:1'b0, nw:4'd1, cnt:4'd1, done:1'b1, fail:1'b0},
    '{enc:1'b1, pass:1'b1, nw:4'd1, cnt:4'd1, done:1'b1, fail:1'b0},
    '{enc:1'b1, pass:1'b1, nw:4'd6, cnt:4'd6, done:1'b1, fail:1'b0}
  };

  localparam logic [KEY_W-1:0] KEY_VA = {8{32'h1357_9BDF}};
  localparam logic [KEY_W-1:0] KEY_VB = {8{32'h2468_ACE0}};
  localparam logic [KEY_W-1:0] KEY_N1 = {8{32'hC0FF_EE11}};
  localparam logic [KEY_W-1:0] KEY_N2 = {8{32'h0BAD_F00D}};

  logic clk = 1'b0;
  logic rst_n = 1'b0, keys_clr_n = 1'b0;
  logic kp_valid = 1'b0, kp_to_nv = 1'b0, kp_bit = 1'b0, tp_req = 1'b0;
  logic cfg_valid = 1'b0, cfg_sop = 1'b0, cfg_eop = 1'b0;
  logic [DATA_W-1:0] cfg_data = '0;
  logic kchk_valid = 1'b0, kchk_pass = 1'b0, rb_req = 1'b0;
  logic fab_valid, dec_valid, dec_key_sel, rb_refuse;
  logic [DATA_W-1:0] fab_data, dec_data;
  logic [KEY_W-1:0] dec_key;
  logic nv_present, vol_present, tamper_on, cfg_done, cfg_fail;

  int checks = 0, failures = 0, cyc = 0;
  int fab_n = 0, dec_n = 0;
  logic [DATA_W-1:0] fab_sum = '0, dec_sum = '0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgsec_ctrl #(.KEY_W(KEY_W), .DATA_W(DATA_W), .ENC_BIT(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .keys_clr_n(keys_clr_n),
    .kp_valid(kp_valid), .kp_to_nv(kp_to_nv), .kp_bit(kp_bit), .tp_req(tp_req),
    .cfg_valid(cfg_valid), .cfg_sop(cfg_sop), .cfg_eop(cfg_eop), .cfg_data(cfg_data),
    .fab_valid(fab_valid), .fab_data(fab_data), .dec_valid(dec_valid), .dec_data(dec_data),
    .dec_key_sel(dec_key_sel), .dec_key(dec_key),
    .kchk_valid(kchk_valid), .kchk_pass(kchk_pass),
    .rb_req(rb_req), .rb_refuse(rb_refuse),
    .nv_present(nv_present), .vol_present(vol_present), .tamper_on(tamper_on),
    .cfg_done(cfg_done), .cfg_fail(cfg_fail)
  );

  always @(negedge clk) begin
    if (fab_valid) begin fab_n <= fab_n + 1; fab_sum <= fab_sum + fab_data; end
    if (dec_valid) begin dec_n <= dec_n + 1; dec_sum <= dec_sum + dec_data; end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG && !finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog: actual cycles=%0d expected below %0d", cyc, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [KEY_W-1:0] act, input logic [KEY_W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic sess_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic load_key(input bit to_nv, input logic [KEY_W-1:0] k, input bit check_mid);
    for (int i = KEY_W - 1; i >= 0; i--) begin
      kp_valid = 1'b1; kp_to_nv = to_nv; kp_bit = k[i];
      @(negedge clk);
      if (check_mid && i == KEY_W - 1)
        chk(vol_present == 1'b0, "R3", "vol_present during reload", KEY_W'(vol_present), '0);
    end
    kp_valid = 1'b0; kp_bit = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_session(input bit enc, input bit pass, input int nw, input int exp_cnt,
                             input bit exp_done, input bit exp_fail, input bit exp_sel,
                             input logic [KEY_W-1:0] exp_key, input int tag, input string req);
    int n0, n1;
    logic [DATA_W-1:0] s0, s1, exp_sum;
    sess_reset();
    n0 = enc ? dec_n : fab_n;
    s0 = enc ? dec_sum : fab_sum;
    exp_sum = '0;
    cfg_valid = 1'b1; cfg_sop = 1'b1; cfg_data = {31'h2A, enc};
    @(negedge clk);
    cfg_valid = 1'b0; cfg_sop = 1'b0;
    if (enc && exp_cnt > 0) begin
      chk(dec_key == exp_key, req, "dec_key", dec_key, exp_key);
      chk(dec_key_sel == exp_sel, req, "dec_key_sel", KEY_W'(dec_key_sel), KEY_W'(exp_sel));
    end
    for (int i = 0; i < nw; i++) begin
      cfg_valid = 1'b1; cfg_eop = (i == nw - 1);
      cfg_data = 32'h1000_0000 + 32'(tag * 256 + i);
      if (i < exp_cnt) exp_sum = exp_sum + cfg_data;
      @(negedge clk);
      cfg_valid = 1'b0; cfg_eop = 1'b0;
      if (enc && i == 0) begin
        kchk_valid = 1'b1; kchk_pass = pass;
        @(negedge clk);
        kchk_valid = 1'b0; kchk_pass = 1'b0;
      end
    end
    repeat (2) @(negedge clk);
    n1 = enc ? dec_n : fab_n;
    s1 = enc ? dec_sum : fab_sum;
    chk((n1 - n0) == exp_cnt, req, "forwarded count", KEY_W'(n1 - n0), KEY_W'(exp_cnt));
    chk((s1 - s0) == exp_sum, req, "forwarded data sum", KEY_W'(s1 - s0), KEY_W'(exp_sum));
    chk(cfg_done == exp_done, req, "cfg_done", KEY_W'(cfg_done), KEY_W'(exp_done));
    chk(cfg_fail == exp_fail, req, "cfg_fail", KEY_W'(cfg_fail), KEY_W'(exp_fail));
  endtask

  initial begin
    repeat (2) @(negedge clk);
    keys_clr_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    // Reset state (R10, R11)
    chk(!cfg_done && !cfg_fail, "R10", "done/fail at reset", KEY_W'({cfg_done, cfg_fail}), '0);
    chk(!nv_present && !vol_present && !tamper_on, "R4", "stores blank at reset",
        KEY_W'({nv_present, vol_present, tamper_on}), '0);
    chk(dec_key == '0, "R11", "dec_key idle", dec_key, '0);

    // Readback refused (R11)
    rb_req = 1'b1; @(negedge clk); rb_req = 1'b0;
    chk(rb_refuse == 1'b1, "R11", "rb_refuse", KEY_W'(rb_refuse), KEY_W'(1));

    // Tamper request without fuse key is ignored (R4)
    tp_req = 1'b1; @(negedge clk); tp_req = 1'b0; @(negedge clk);
    chk(tamper_on == 1'b0, "R4", "tamper without fuse key", KEY_W'(tamper_on), '0);

    // Encrypted stream with no key fails at header (R8)
    run_session(1'b1, 1'b1, 2, 0, 1'b0, 1'b1, 1'b0, '0, 1, "R8");

    // Load volatile key (R1)
    load_key(1'b0, KEY_VA, 1'b0);
    chk(vol_present == 1'b1, "R1", "vol_present after load", KEY_W'(vol_present), KEY_W'(1));

    // Table of sessions (R6, R8, R9)
    for (int v = 0; v < 6; v++) begin
      run_session(VEC[v].enc, VEC[v].pass, int'(VEC[v].nw), int'(VEC[v].cnt),
                  VEC[v].done, VEC[v].fail, 1'b0, KEY_VA, 10 + v, VEC[v].enc ? "R9" : "R6");
    end

    // Session reset keeps stores (R10)
    sess_reset();
    chk(vol_present == 1'b1, "R10", "vol key kept across rst_n", KEY_W'(vol_present), KEY_W'(1));

    // Failure is sticky: further header ignored (R10)
    run_session(1'b1, 1'b0, 2, 1, 1'b0, 1'b1, 1'b0, KEY_VA, 20, "R10");
    cfg_valid = 1'b1; cfg_sop = 1'b1; cfg_data = '0; @(negedge clk);
    cfg_valid = 1'b0; cfg_sop = 1'b0; @(negedge clk);
    chk(cfg_fail && !cfg_done, "R10", "fail persists", KEY_W'({cfg_fail, cfg_done}), KEY_W'(2));

    // Volatile reload (R3)
    load_key(1'b0, KEY_VB, 1'b1);
    chk(vol_present == 1'b1, "R3", "vol_present after reload", KEY_W'(vol_present), KEY_W'(1));
    run_session(1'b1, 1'b1, 2, 2, 1'b1, 1'b0, 1'b0, KEY_VB, 30, "R3");

    // Fuse key wins when both present (R8, R1)
    load_key(1'b1, KEY_N1, 1'b0);
    chk(nv_present == 1'b1, "R1", "nv_present after load", KEY_W'(nv_present), KEY_W'(1));
    run_session(1'b1, 1'b1, 2, 2, 1'b1, 1'b0, 1'b1, KEY_N1, 31, "R8");

    // Fuse store is one-time (R2)
    load_key(1'b1, KEY_N2, 1'b0);
    run_session(1'b1, 1'b1, 1, 1, 1'b1, 1'b0, 1'b1, KEY_N1, 32, "R2");

    // Set tamper protection (R4)
    tp_req = 1'b1; @(negedge clk); tp_req = 1'b0; @(negedge clk);
    chk(tamper_on == 1'b1, "R4", "tamper set", KEY_W'(tamper_on), KEY_W'(1));

    // Plain stream under tamper fails (R7)
    run_session(1'b0, 1'b0, 3, 0, 1'b0, 1'b1, 1'b0, '0, 33, "R7");

    // Programming locked under tamper (R5): a write would drop vol_present
    kp_valid = 1'b1; kp_to_nv = 1'b0; kp_bit = 1'b1; @(negedge clk);
    kp_valid = 1'b0; @(negedge clk);
    chk(vol_present == 1'b1, "R5", "vol store locked", KEY_W'(vol_present), KEY_W'(1));
    load_key(1'b1, KEY_N2, 1'b0);
    run_session(1'b1, 1'b1, 2, 2, 1'b1, 1'b0, 1'b1, KEY_N1, 34, "R5");

    // Wrong key under tamper still fails (R9)
    run_session(1'b1, 1'b0, 3, 1, 1'b0, 1'b1, 1'b1, KEY_N1, 35, "R9");

    // Readback still refused, tamper survives rst_n (R11, R4)
    rb_req = 1'b1; @(negedge clk); rb_req = 1'b0;
    chk(rb_refuse == 1'b1, "R11", "rb_refuse later", KEY_W'(rb_refuse), KEY_W'(1));
    sess_reset();
    chk(tamper_on == 1'b1 && dec_key == '0, "R4", "tamper kept, key hidden",
        KEY_W'(tamper_on), KEY_W'(1));

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule